// File: doc/BRIEF.md
# MDIO Management Master

This block is a register-driven master for the two-wire management bus that controls an external PHY. It runs one read or one write at a time. Software first loads a 16-bit data register. It then writes a control word that carries the PHY address, the register address, the direction, a preamble-skip flag, a clock divisor code and a start/busy flag. The block produces the management clock and drives the data line through an output value and an output enable. For reads it samples the data line through a separate input. When the transaction ends, the busy flag clears by itself. After a read, the data register holds the 16 bits returned by the PHY.

The frame has 64 bit slots. The first 32 are a preamble of ones. Then come start `01`, opcode (`10` read, `01` write), five PHY address bits, five register address bits, two turnaround bits and sixteen data bits. Every field is sent most significant bit first. The master changes the data line only when the management clock falls. It samples the line when the clock rises. A global enable input gates the management clock. While it is low, a transaction in progress pauses with the clock held at its current level. All register writes arrive on a plain write strobe with a select bit. There is no stream interface and no back-pressure: a write is accepted or ignored in the cycle it is presented.

Top module: `mdio_master`

## Requirements
- R1: After reset, the control readback and data readback are zero, `mdc` is low and `mdio_oe` is low.
- R2: The control word layout is: bits 4:0 register address, bits 12:8 PHY address, bit 16 write (1) / read (0), bit 17 busy/start, bit 18 preamble skip, bits 23:20 divisor code. All other bits read as zero. `reg_sel`=1 selects the control word and `reg_sel`=0 selects the data register, whose write data is taken from `reg_wdata[15:0]`. A control write made while the block is idle is returned unchanged by `ctrl_rd`. The busy bit reads 1 once the write has started a transaction.
- R3: A control write with bit 17 set, made while idle, starts a transaction. Bit 17 stays 1 until the last frame bit has been clocked out, then returns to 0 on its own.
- R4: Divisor codes 0 to 15 give management clock periods of 4, 6, 8, 12, 16, 20, 24, 28, 30, 32, 36, 40, 44, 48, 54 and 60 system clocks. The clock spends equal time high and low.
- R5: Without preamble skip, the frame is 32 ones, then `01`, then the opcode, PHY address, register address, turnaround and data, 64 clock periods in total.
- R6: With preamble skip, the frame starts directly at the start bits and lasts 32 clock periods.
- R7: In a read, `mdio_oe` is low for both turnaround slots and all 16 data slots. The bit sampled at each rising clock edge of the data slots is shifted into the data register MSB first.
- R8: In a write, the master drives turnaround `10`, followed by the 16 bits of the data register MSB first.
- R9: While busy, `mdio_o` changes only in the cycle in which `mdc` falls.
- R10: While `mdc_en` is low, `mdc` does not change and a transaction in progress stays busy. When `mdc_en` returns high, the transaction finishes normally.
- R11: Control and data register writes made while busy are ignored. Neither the control readback nor the frame on the wire changes.
- R12: When not busy, `mdc` is low and `mdio_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mdc_en | input | 1 | Global management clock enable |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 1 = control word, 0 = data register |
| reg_wdata | input | 32 | Register write data |
| ctrl_rd | output | 32 | Control word readback with live busy bit |
| data_rd | output | 16 | Data register readback |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input |

## Verification
An error in the slot counter shows on the wire within one management clock period. A field can shift by a slot, the frame can end early or late, or the output enable can stay high during a read turnaround. Each of these shows up as a wrong captured frame or a wrong rise count once busy clears. A wrong divisor entry or counter reload changes the time between rising edges from the very first period. Broken busy or ignore logic shows in the control readback in the cycle after the intruding write. An error in the read shift path shows in the data readback as soon as busy drops.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int DATA_W   = 16;
  localparam int ADDR_W   = 5;
  localparam int CODE_W   = 4;
  localparam int SLOTS    = 64;
  localparam int SLOT_W   = $clog2(SLOTS);
  localparam int PRE_LEN  = 32;
  localparam int TA_SLOT  = 46;
  localparam int DAT_SLOT = 48;
  localparam int HALF_W   = 5;

  localparam int F_REG   = 0;
  localparam int F_PHY   = 8;
  localparam int F_WR    = 16;
  localparam int F_BUSY  = 17;
  localparam int F_NOPRE = 18;
  localparam int F_DIV   = 20;

  typedef struct packed {
    logic [CODE_W-1:0] div;
    logic              nopre;
    logic              wr;
    logic [ADDR_W-1:0] phy;
    logic [ADDR_W-1:0] regad;
  } mdio_cmd_t;

  function automatic logic [HALF_W-1:0] half_of(input logic [CODE_W-1:0] code);
    logic [HALF_W-1:0] h;
    case (code)
      4'd0:  h = 5'd2;
      4'd1:  h = 5'd3;
      4'd2:  h = 5'd4;
      4'd3:  h = 5'd6;
      4'd4:  h = 5'd8;
      4'd5:  h = 5'd10;
      4'd6:  h = 5'd12;
      4'd7:  h = 5'd14;
      4'd8:  h = 5'd15;
      4'd9:  h = 5'd16;
      4'd10: h = 5'd18;
      4'd11: h = 5'd20;
      4'd12: h = 5'd22;
      4'd13: h = 5'd24;
      4'd14: h = 5'd27;
      default: h = 5'd30;
    endcase
    return h;
  endfunction
endpackage

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [31:0]       reg_wdata,
  input  logic              done,
  input  logic              shift_en,
  input  logic              shift_bit,
  output mdio_cmd_t         cmd,
  output logic              busy,
  output logic              start,
  output logic [DATA_W-1:0] data_q
);
  logic ctrl_wr, data_wr;

  assign ctrl_wr = reg_wr && reg_sel && !busy;
  assign data_wr = reg_wr && !reg_sel && !busy;
  assign start   = ctrl_wr && reg_wdata[F_BUSY];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd    <= '0;
      busy   <= 1'b0;
      data_q <= '0;
    end else begin
      if (ctrl_wr) begin
        cmd.div   <= reg_wdata[F_DIV +: CODE_W];
        cmd.nopre <= reg_wdata[F_NOPRE];
        cmd.wr    <= reg_wdata[F_WR];
        cmd.phy   <= reg_wdata[F_PHY +: ADDR_W];
        cmd.regad <= reg_wdata[F_REG +: ADDR_W];
      end
      if (start)
        busy <= 1'b1;
      else if (done)
        busy <= 1'b0;
      if (data_wr)
        data_q <= reg_wdata[DATA_W-1:0];
      else if (shift_en)
        data_q <= {data_q[DATA_W-2:0], shift_bit};
    end
  end
endmodule

// File: rtl/mdio_clkgen.sv
module mdio_clkgen
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              run,
  input  logic [CODE_W-1:0] code,
  output logic              mdc,
  output logic              rise,
  output logic              fall
);
  logic [HALF_W-1:0] cnt;
  logic [HALF_W-1:0] half;
  logic              tick;

  assign half = half_of(code);
  assign tick = run && (cnt == half - 1'b1);
  assign rise = tick && !mdc;
  assign fall = tick && mdc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (start) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (tick) begin
      cnt <= '0;
      mdc <= !mdc;
    end else if (run) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_nopre,
  input  mdio_cmd_t         cmd,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rise,
  input  logic              fall,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              done,
  output logic              shift_en,
  output logic              shift_bit,
  output logic [SLOT_W-1:0] idx
);
  logic             active;
  logic [SLOTS-1:0] frame_bits;
  logic [1:0]       opcode;
  logic             drive;

  assign opcode     = cmd.wr ? 2'b01 : 2'b10;
  assign frame_bits = {{PRE_LEN{1'b1}}, 2'b01, opcode, cmd.phy, cmd.regad, 2'b10, wdata};
  assign drive      = active && (cmd.wr || idx < SLOT_W'(TA_SLOT));
  assign mdio_oe    = drive;
  assign mdio_o     = drive ? frame_bits[SLOT_W'(SLOTS-1) - idx] : 1'b0;
  assign done       = active && fall && (idx == SLOT_W'(SLOTS-1));
  assign shift_en   = active && rise && !cmd.wr && (idx >= SLOT_W'(DAT_SLOT));
  assign shift_bit  = mdio_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      idx    <= '0;
    end else if (start) begin
      active <= 1'b1;
      idx    <= start_nopre ? SLOT_W'(PRE_LEN) : '0;
    end else if (active && fall) begin
      if (idx == SLOT_W'(SLOTS-1)) begin
        active <= 1'b0;
        idx    <= '0;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mdc_en,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       ctrl_rd,
  output logic [DATA_W-1:0] data_rd,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  mdio_cmd_t         cmd;
  logic              busy, start, done, shift_en, shift_bit, rise, fall;
  logic [SLOT_W-1:0] bit_idx;

  mdio_regs i_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .done(done), .shift_en(shift_en),
    .shift_bit(shift_bit), .cmd(cmd), .busy(busy), .start(start),
    .data_q(data_rd)
  );

  mdio_clkgen i_clkgen (
    .clk(clk), .rst_n(rst_n), .start(start), .run(busy && mdc_en),
    .code(cmd.div), .mdc(mdc), .rise(rise), .fall(fall)
  );

  mdio_frame i_frame (
    .clk(clk), .rst_n(rst_n), .start(start),
    .start_nopre(reg_wdata[F_NOPRE]), .cmd(cmd), .wdata(data_rd),
    .rise(rise), .fall(fall), .mdio_i(mdio_i), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .done(done), .shift_en(shift_en),
    .shift_bit(shift_bit), .idx(bit_idx)
  );

  always_comb begin
    ctrl_rd                      = '0;
    ctrl_rd[F_REG +: ADDR_W]     = cmd.regad;
    ctrl_rd[F_PHY +: ADDR_W]     = cmd.phy;
    ctrl_rd[F_WR]                = cmd.wr;
    ctrl_rd[F_BUSY]              = busy;
    ctrl_rd[F_NOPRE]             = cmd.nopre;
    ctrl_rd[F_DIV +: CODE_W]     = cmd.div;
  end
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk
  import mdio_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              mdc_en,
  input logic              reg_wr,
  input logic              reg_sel,
  input logic [31:0]       ctrl_rd,
  input logic              mdc,
  input logic              mdio_o,
  input logic              mdio_oe,
  input logic [SLOT_W-1:0] bit_idx
);
  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_rd[F_BUSY] |-> (!mdc && !mdio_oe));

  // R10
  gated_mdc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mdc_en |=> $stable(mdc));

  // R11
  busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_rd[F_BUSY] && reg_wr && reg_sel)
      |=> $stable({ctrl_rd[31:F_NOPRE], ctrl_rd[F_WR:0]}));

  // R9
  drive_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_rd[F_BUSY] && $past(ctrl_rd[F_BUSY]) && !$fell(mdc)) |-> $stable(mdio_o));

  // R7
  read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_rd[F_BUSY] && !ctrl_rd[F_WR] && bit_idx >= SLOT_W'(TA_SLOT)) |-> !mdio_oe);
endmodule

bind mdio_master mdio_master_chk i_chk (
  .clk(clk), .rst_n(rst_n), .mdc_en(mdc_en), .reg_wr(reg_wr),
  .reg_sel(reg_sel), .ctrl_rd(ctrl_rd), .mdc(mdc), .mdio_o(mdio_o),
  .mdio_oe(mdio_oe), .bit_idx(bit_idx)
);

// File: tb/test_mdio_master.sv
`timescale 1ns/100ps
module test_mdio_master;
  localparam real CLK_NS = 5.0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mdc_en = 1'b1;
  logic        reg_wr = 1'b0;
  logic        reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] ctrl_rd;
  logic [15:0] data_rd;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  mdio_master i_mdio_master (
    .clk(clk), .rst_n(rst_n), .mdc_en(mdc_en), .reg_wr(reg_wr),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .ctrl_rd(ctrl_rd),
    .data_rd(data_rd), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_i)
  );

  function automatic int ratio(input logic [3:0] c);
    case (c)
      4'd0: return 4;   4'd1: return 6;   4'd2: return 8;   4'd3: return 12;
      4'd4: return 16;  4'd5: return 20;  4'd6: return 24;  4'd7: return 28;
      4'd8: return 30;  4'd9: return 32;  4'd10: return 36; 4'd11: return 40;
      4'd12: return 44; 4'd13: return 48; 4'd14: return 54; default: return 60;
    endcase
  endfunction

  function automatic logic [63:0] exp_frame(input logic wr, input logic [4:0] phy,
                                            input logic [4:0] ra, input logic [15:0] wd);
    return {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), phy, ra, 2'b10, wd};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // PHY model and wire monitor
  int          seq_now = 0, seq_seen = 0;
  int          base = 0, rc = 0, exp_ratio = 4;
  logic        cap_o [64];
  logic        cap_oe[64];
  bit          perr = 0, serr = 0;
  logic        lowval = 1'b0;
  realtime     last_t = 0;
  logic [15:0] phy_word = '0;

  always @(mdc) begin
    #1;
    if (seq_seen != seq_now) begin
      seq_seen = seq_now; rc = 0; perr = 0; serr = 0;
    end
    if (mdc) begin
      if (base + rc < 64) begin
        cap_o[base + rc]  = mdio_o;
        cap_oe[base + rc] = mdio_oe;
      end
      if (rc > 0 && ($realtime - last_t) != exp_ratio * CLK_NS) perr = 1;
      if (rc > 0 && mdio_o !== lowval) serr = 1;
      last_t = $realtime;
      rc++;
    end else begin
      if (base + rc >= 48 && base + rc < 64) mdio_i = phy_word[63 - (base + rc)];
      else mdio_i = 1'b1;
      lowval = mdio_o;
    end
  end

  task automatic reg_write(input logic sel, input logic [31:0] v);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic run_op(input logic [3:0] code, input logic [4:0] phy, input logic [4:0] ra,
                        input logic wr, input logic nopre, input logic [15:0] wd,
                        input logic [15:0] pw, input bit intrude, input bit gate);
    logic [31:0] cw;
    logic [63:0] ef;
    bit          bad_oe, bad_o, bad_g;
    int          n;
    logic        m;
    phy_word  = pw;
    base      = nopre ? 32 : 0;
    exp_ratio = ratio(code);
    seq_now++;
    reg_write(1'b0, {16'h0, wd});
    cw = {8'h0, code, 1'b0, nopre, 1'b1, wr, 3'b0, phy, 3'b0, ra};
    reg_write(1'b1, cw);
    chk(ctrl_rd == cw, "R2 control readback", ctrl_rd, cw);
    if (intrude) begin
      repeat (20) @(negedge clk);
      reg_write(1'b0, {16'h0, ~wd});
      reg_write(1'b1, cw ^ 32'h00F5_1F1F);
      chk(ctrl_rd == cw, "R11 control write while busy", ctrl_rd, cw);
    end
    if (gate) begin
      repeat (10) @(negedge clk);
      mdc_en = 1'b0;
      m = mdc;
      bad_g = 0;
      repeat (300) begin
        @(negedge clk);
        if (mdc !== m || ctrl_rd[17] !== 1'b1) bad_g = 1;
      end
      chk(!bad_g, "R10 clock frozen and busy held", {63'h0, mdc}, {63'h0, m});
      mdc_en = 1'b1;
    end
    n = 0;
    while (ctrl_rd[17] && n < 20000) begin
      @(negedge clk);
      n++;
    end
    @(negedge clk);
    chk(!ctrl_rd[17], "R3 busy self-clears", {63'h0, ctrl_rd[17]}, 64'h0);
    ef = exp_frame(wr, phy, ra, wd);
    bad_oe = 0; bad_o = 0;
    for (int i = base; i < 64; i++) begin
      if (cap_oe[i] !== (wr || i < 46)) bad_oe = 1;
      if ((wr || i < 46) && cap_o[i] !== ef[63 - i]) bad_o = 1;
    end
    chk(!bad_oe, wr ? "R8 drive enable" : "R7 turnaround release", {63'h0, bad_oe}, 64'h0);
    chk(!bad_o, wr ? "R8 write frame bits" : "R5 read frame bits", {63'h0, bad_o}, 64'h0);
    chk(rc == 64 - base, nopre ? "R6 short frame length" : "R5 full frame length",
        64'(rc), 64'(64 - base));
    if (!gate) chk(!perr, "R4 clock period", {63'h0, perr}, 64'h0);
    chk(!serr, "R9 output steady across rise", {63'h0, serr}, 64'h0);
    if (wr)
      chk(data_rd == wd, intrude ? "R11 data write while busy" : "R3 data kept",
          64'(data_rd), 64'(wd));
    else
      chk(data_rd == pw, "R7 read result", 64'(data_rd), 64'(pw));
    chk(!mdc && !mdio_oe, "R12 idle lines", {62'h0, mdc, mdio_oe}, 64'h0);
  endtask

  initial begin
    int lim = 0;
    while (lim < 150000) begin
      @(posedge clk);
      lim++;
    end
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    chk(ctrl_rd == 0 && data_rd == 0 && !mdc && !mdio_oe, "R1 reset state",
        {ctrl_rd, data_rd, 14'h0, mdc, mdio_oe}, 64'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    reg_write(1'b1, 32'h0015_0A03);
    chk(ctrl_rd == 32'h0015_0A03 && !mdc, "R2 store without start",
        ctrl_rd, 64'h0015_0A03);
    run_op(4'd0,  5'h11, 5'h05, 1'b1, 1'b0, 16'hA5C3, 16'h0000, 0, 0);
    run_op(4'd15, 5'h1F, 5'h1F, 1'b0, 1'b1, 16'h0000, 16'hBEEF, 0, 0);
    run_op(4'd8,  5'h00, 5'h00, 1'b0, 1'b0, 16'h1234, 16'h8001, 0, 0);
    run_op(4'd14, 5'h0A, 5'h15, 1'b1, 1'b1, 16'hFFFF, 16'h0000, 1, 0);
    run_op(4'd3,  5'h03, 5'h10, 1'b0, 1'b1, 16'h0000, 16'h6A6A, 0, 1);
    for (int k = 0; k < 8; k++) begin
      logic [31:0] r;
      r = $urandom;
      run_op(r[3:0], r[8:4], r[13:9], r[14], r[15], $urandom, $urandom, 0, 0);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule